// File: doc/BRIEF.md
# BCD Real-Time Clock and Calendar Counter

This block keeps the time of day and the calendar date as packed binary-coded-decimal words. It moves forward by one second each time the one-second tick input pulses. The time word holds seconds, minutes and hours in 24-hour form. The calendar word holds century, year, month, weekday and day of month. Each field wraps over in BCD. A minute change, a day change and every tick each raise a sticky event output.

To change the time, a host uses a handshake. It first sets a freeze request for the time counters, the calendar counters, or both. The block raises an update acknowledge. While a freeze request is held, the host writes new words through the register port, then clears the request to restart counting.

A written word that is out of range is refused and flags an invalid output. A word written while its counters are running is dropped. The register port is plain control access with a single-cycle write strobe and a combinational read. No data stream passes through the block, so it has no back-pressure.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time reads 00:00:00 (0x00000000), the calendar reads century 0x20, year 0x00, month 0x01, weekday 7, date 0x01 (0x01E10020), control reads 0, and every status and invalid output is 0.
- R2: Control bit 0 freezes the time counters and control bit 1 freezes the calendar counters; ticks during a freeze leave the frozen word unchanged.
- R3: When the control request bits go from none set to any set, upd_ack (status bit 0) is 1 two clock edges after the edge that writes the control word.
- R4: A write to the time word while control bit 0 is clear, or to the calendar word while control bit 1 is clear, changes nothing.
- R5: The time word holds seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16, all BCD. Seconds 59 carry into minutes, minutes 59 carry into hours, and hour 23 wraps to 00 and carries one day into the calendar.
- R6: The calendar word holds century in bits 6:0, year in 15:8, month in 20:16, weekday in 23:21 and date in 29:24. The date wraps after 31, 30 or 28/29 days, with 29 in February when the year is divisible by 4. Month 12 wraps to 1 and carries into the year. Year 99 wraps to 00 and carries into the century. Weekday goes from 7 to 1.
- R7: Status bit 2 (sec_evt) is set by every tick, including a tick during a freeze. Bit 3 (min_evt) is set when counting changes the minute. Bit 4 (day_evt) is set when counting changes the date.
- R8: A write to address 3 clears each status bit whose data bit is 1. A set in the same cycle wins over the clear.
- R9: A write made during a freeze is refused when a field is out of range or has a non-decimal digit. Allowed ranges are sec 00–59, min 00–59, hour 00–23, century 19–20, month 01–12, weekday 1–7, and date 01 to the month length. A refusal sets time_invalid or cal_invalid (validity bits 0 and 1); the next accepted write clears the flag.
- R10: Register addresses are: 0 control, 1 time, 2 calendar, 3 status (read) or clear (write), 4 validity (read-only). rd_data shows the addressed word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data, combinational |
| upd_ack | output | 1 | Sticky update acknowledge |
| sec_evt | output | 1 | Sticky second event |
| min_evt | output | 1 | Sticky minute event |
| day_evt | output | 1 | Sticky day event |
| time_invalid | output | 1 | Last frozen time write was refused |
| cal_invalid | output | 1 | Last frozen calendar write was refused |

## Verification
A tick and a status clear can arrive in the same cycle, and the tick's set must win. The bench provokes this by pulsing tick_1s in the same cycle as a clear write with the second-event bit set. It then expects sec_evt to still read 1, and expects a lone clear afterwards to drop it to 0. A write to the time word can also meet a tick while counting runs. The bench expects the written value to be dropped and the word to show only the tick's advance.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int WORD_W = 32;
  localparam int STAT_W = 5;

  function automatic logic digits_ok(input logic [7:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [7:0] yr);
    logic [7:0] bin;
    bin = 8'(v_hi(yr) * 10) + {4'd0, yr[3:0]};
    return bin[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] v_hi(input logic [7:0] v);
    return {4'd0, v[7:4]};
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02: return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic time_ok(input logic [31:0] w);
    logic [7:0] s, m, h;
    s = {1'b0, w[6:0]};
    m = {1'b0, w[14:8]};
    h = {2'b0, w[21:16]};
    return digits_ok(s) && s <= 8'h59 && digits_ok(m) && m <= 8'h59 &&
           digits_ok(h) && h <= 8'h23;
  endfunction

  function automatic logic cal_ok(input logic [31:0] w);
    logic [7:0] c, y, mo, d;
    logic [2:0] wd;
    c  = {1'b0, w[6:0]};
    y  = w[15:8];
    mo = {3'b0, w[20:16]};
    wd = w[23:21];
    d  = {2'b0, w[29:24]};
    return (c == 8'h19 || c == 8'h20) && digits_ok(y) &&
           digits_ok(mo) && mo >= 8'h01 && mo <= 8'h12 &&
           wd != 3'd0 && digits_ok(d) && d >= 8'h01 && d <= month_days(mo, y);
  endfunction
endpackage

// File: rtl/rtc_time_cnt.sv
module rtc_time_cnt
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hold,
  input  logic              load,
  input  logic [WORD_W-1:0] ld_val,
  output logic [WORD_W-1:0] time_q,
  output logic              min_step,
  output logic              day_carry
);
  logic [7:0] sec, mins, hr;
  logic run, sec_wrap, min_wrap, hr_wrap;

  assign run      = tick && !hold && !load;
  assign sec_wrap = sec == 8'h59;
  assign min_wrap = mins == 8'h59;
  assign hr_wrap  = hr == 8'h23;
  assign min_step  = run && sec_wrap;
  assign day_carry = run && sec_wrap && min_wrap && hr_wrap;
  assign time_q = {10'd0, hr[5:0], 1'b0, mins[6:0], 1'b0, sec[6:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= 8'h00; mins <= 8'h00; hr <= 8'h00;
    end else if (load) begin
      sec  <= {1'b0, ld_val[6:0]};
      mins <= {1'b0, ld_val[14:8]};
      hr   <= {2'b0, ld_val[21:16]};
    end else if (run) begin
      sec <= sec_wrap ? 8'h00 : bcd_inc(sec);
      if (sec_wrap) mins <= min_wrap ? 8'h00 : bcd_inc(mins);
      if (sec_wrap && min_wrap) hr <= hr_wrap ? 8'h00 : bcd_inc(hr);
    end
  end

  p_hold_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> $stable(time_q));
  p_time_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    time_ok(time_q));
  p_midnight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |=> (time_q == '0));
endmodule

// File: rtl/rtc_cal_cnt.sv
module rtc_cal_cnt
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              day_inc,
  input  logic              load,
  input  logic [WORD_W-1:0] ld_val,
  output logic [WORD_W-1:0] cal_q
);
  logic [7:0] cent, yr, mon, dt;
  logic [2:0] wd;
  logic last_day, last_mon, last_yr;

  assign last_day = dt == month_days(mon, yr);
  assign last_mon = mon == 8'h12;
  assign last_yr  = yr == 8'h99;
  assign cal_q = {2'd0, dt[5:0], wd, mon[4:0], yr, 1'b0, cent[6:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cent <= 8'h20; yr <= 8'h00; mon <= 8'h01; dt <= 8'h01; wd <= 3'd7;
    end else if (load) begin
      cent <= {1'b0, ld_val[6:0]};
      yr   <= ld_val[15:8];
      mon  <= {3'b0, ld_val[20:16]};
      wd   <= ld_val[23:21];
      dt   <= {2'b0, ld_val[29:24]};
    end else if (day_inc) begin
      wd <= (wd == 3'd7) ? 3'd1 : wd + 3'd1;
      dt <= last_day ? 8'h01 : bcd_inc(dt);
      if (last_day) mon <= last_mon ? 8'h01 : bcd_inc(mon);
      if (last_day && last_mon) yr <= last_yr ? 8'h00 : bcd_inc(yr);
      if (last_day && last_mon && last_yr) cent <= bcd_inc(cent);
    end
  end

  p_date_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dt >= 8'h01 && dt <= month_days(mon, yr) && mon >= 8'h01 && mon <= 8'h12));
  p_wday_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (day_inc && !load && wd == 3'd7) |=> (cal_q[23:21] == 3'd1));
endmodule

// File: rtl/rtc_status.sv
module rtc_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)       q[i] <= 1'b0;
      else if (set[i])  q[i] <= 1'b1;
      else if (clr[i])  q[i] <= 1'b0;
    end
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1s,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              upd_ack,
  output logic              sec_evt,
  output logic              min_evt,
  output logic              day_evt,
  output logic              time_invalid,
  output logic              cal_invalid
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CAL  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(4);

  logic [1:0] ctrl;
  logic req_q, req_any, ack_rise;
  logic wr_ctrl, wr_time, wr_cal, wr_clr;
  logic load_t, load_c, min_step, day_carry, day_inc;
  logic bad_t, bad_c;
  logic [WORD_W-1:0] time_w, cal_w;
  logic [STAT_W-1:0] st_set, st_clr, st_q;

  assign wr_ctrl = wr_en && wr_addr == A_CTRL;
  assign wr_time = wr_en && wr_addr == A_TIME;
  assign wr_cal  = wr_en && wr_addr == A_CAL;
  assign wr_clr  = wr_en && wr_addr == A_STAT;
  assign load_t  = wr_time && ctrl[0] && time_ok(wr_data);
  assign load_c  = wr_cal && ctrl[1] && cal_ok(wr_data);
  assign day_inc = day_carry && !ctrl[1];
  assign req_any = |ctrl;
  assign ack_rise = req_any && !req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= 2'b00; req_q <= 1'b0; bad_t <= 1'b0; bad_c <= 1'b0;
    end else begin
      req_q <= req_any;
      if (wr_ctrl) ctrl <= wr_data[1:0];
      if (wr_time && ctrl[0]) bad_t <= !time_ok(wr_data);
      if (wr_cal && ctrl[1])  bad_c <= !cal_ok(wr_data);
    end
  end

  rtc_time_cnt u_time (
    .clk(clk), .rst_n(rst_n), .tick(tick_1s), .hold(ctrl[0]), .load(load_t),
    .ld_val(wr_data), .time_q(time_w), .min_step(min_step), .day_carry(day_carry)
  );

  rtc_cal_cnt u_cal (
    .clk(clk), .rst_n(rst_n), .day_inc(day_inc), .load(load_c),
    .ld_val(wr_data), .cal_q(cal_w)
  );

  assign st_set = {day_inc, min_step, tick_1s, 1'b0, ack_rise};
  assign st_clr = wr_clr ? wr_data[STAT_W-1:0] : '0;

  rtc_status #(.N(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .set(st_set), .clr(st_clr), .q(st_q)
  );

  assign upd_ack = st_q[0];
  assign sec_evt = st_q[2];
  assign min_evt = st_q[3];
  assign day_evt = st_q[4];
  assign time_invalid = bad_t;
  assign cal_invalid  = bad_c;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {30'd0, ctrl};
      A_TIME:  rd_data = time_w;
      A_CAL:   rd_data = cal_w;
      A_STAT:  rd_data = {{(32-STAT_W){1'b0}}, st_q};
      A_VAL:   rd_data = {30'd0, bad_c, bad_t};
      default: rd_data = 32'd0;
    endcase
  end

  p_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_any && !req_q) |=> upd_ack);
  p_ignore_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_time && !ctrl[0] && !tick_1s) |=> $stable(time_w));
  p_ignore_cal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cal && !ctrl[1] && !day_carry) |=> $stable(cal_w));
  p_sec_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1s |=> sec_evt);
  p_bad_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_time && ctrl[0] && !time_ok(wr_data)) |=> (time_invalid && $stable(time_w)));
endmodule

// File: tb/bcd_rtc_core_bench.sv
`timescale 1ns/1ps
module bcd_rtc_core_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick_1s = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic upd_ack, sec_evt, min_evt, day_evt, time_invalid, cal_invalid;
  int checks = 0, failures = 0;
  bit done = 0;
  int s, m, h, d, mo, y, wd;
  bit minchg, daychg;

  always #2.5 clk = ~clk;

  bcd_rtc_core u_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .upd_ack(upd_ack),
    .sec_evt(sec_evt), .min_evt(min_evt), .day_evt(day_evt),
    .time_invalid(time_invalid), .cal_invalid(cal_invalid)
  );

  function automatic int dim(int mon, int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic logic [31:0] enc_time(int hh, int mm, int ss);
    return {10'd0, bcd(hh)[5:0], 1'b0, bcd(mm)[6:0], 1'b0, bcd(ss)[6:0]};
  endfunction
  function automatic logic [31:0] enc_cal(int dd, int mn, int yy, int ww);
    return {2'd0, bcd(dd)[5:0], 3'(ww), bcd(mn)[4:0], bcd(yy % 100), 1'b0, bcd(yy / 100)[6:0]};
  endfunction

  task automatic advance();
    s++;
    if (s == 60) begin
      s = 0; m++; minchg = 1;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; daychg = 1; wd = (wd == 7) ? 1 : wd + 1; d++;
          if (d > dim(mo, y)) begin
            d = 1; mo++;
            if (mo == 13) begin mo = 1; y++; end
          end
        end
      end
    end
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] v);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic rd(logic [2:0] a, output logic [31:0] v);
    rd_addr = a; #0.5; v = rd_data;
  endtask
  task automatic tick();
    @(negedge clk); tick_1s = 1;
    @(negedge clk); tick_1s = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, t0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(1, v); check("R1 time", v, 32'h0);
    rd(2, v); check("R1 cal", v, 32'h01E10020);
    rd(0, v); check("R1 ctrl", v, 32'h0);
    check("R1 status", {upd_ack, sec_evt, min_evt, day_evt, time_invalid, cal_invalid}, 0);

    // R4 write ignored while running
    wr(1, 32'h00123456); rd(1, v); check("R4 time ignored", v, 32'h0);
    wr(2, 32'h15420719); rd(2, v); check("R4 cal ignored", v, 32'h01E10020);

    // R3 ack two edges after control write
    wr(0, 32'h3);
    @(negedge clk); check("R3 upd_ack", upd_ack, 1);
    rd(3, v); check("R10 status read", v[0], 1);

    // R2 frozen ticks, R7 sec_evt during freeze
    wr(1, 32'h00235958); wr(2, enc_cal(28, 2, 2001, 3));
    tick(); tick(); tick();
    rd(1, v); check("R2 time frozen", v, 32'h00235958);
    rd(2, v); check("R2 cal frozen", v, enc_cal(28, 2, 2001, 3));
    check("R7 sec_evt on frozen tick", sec_evt, 1);

    // R9 invalid writes
    wr(1, 32'h00120060); check("R9 time_invalid", time_invalid, 1);
    rd(1, v); check("R9 time kept", v, 32'h00235958);
    rd(4, v); check("R10 validity", v, 32'h1);
    wr(2, enc_cal(30, 2, 2001, 3)); check("R9 cal_invalid Feb30", cal_invalid, 1);
    wr(2, enc_cal(29, 2, 2004, 1)); check("R9 cal valid leap", cal_invalid, 0);
    wr(1, 32'h00235958); check("R9 time_invalid cleared", time_invalid, 0);

    // R8 clear and set in the same cycle
    wr(3, 32'h1F); check("R8 clear", {upd_ack, sec_evt}, 0);
    @(negedge clk); tick_1s = 1; wr_en = 1; wr_addr = 3; wr_data = 32'h04;
    @(negedge clk); tick_1s = 0; wr_en = 0;
    check("R8 set wins", sec_evt, 1);
    wr(3, 32'h04); check("R8 lone clear", sec_evt, 0);

    // R4 write meeting a tick while running
    wr(0, 32'h0);
    rd(1, t0);
    @(negedge clk); tick_1s = 1; wr_en = 1; wr_addr = 1; wr_data = 32'h00010101;
    @(negedge clk); tick_1s = 0; wr_en = 0;
    rd(1, v); check("R4 write vs tick", v, 32'h00235959);

    // R5 R6 R7 random runs near rollovers
    for (int it = 0; it < 40; it++) begin
      int k;
      y  = 1900 + int'($urandom_range(198));
      mo = ($urandom_range(3) == 0) ? 12 : 1 + int'($urandom_range(11));
      d  = ($urandom_range(1) == 0) ? dim(mo, y) : 1 + int'($urandom_range(dim(mo, y) - 1));
      wd = 1 + int'($urandom_range(6));
      h  = ($urandom_range(2) == 0) ? int'($urandom_range(23)) : 23;
      m  = ($urandom_range(2) == 0) ? int'($urandom_range(59)) : 59;
      s  = 56 + int'($urandom_range(3));
      if (it == 0) begin y = 2099; mo = 12; d = 31; h = 23; m = 59; s = 59; end
      if (it == 1) begin y = 1999; mo = 12; d = 31; h = 23; m = 59; s = 59; wd = 7; end
      if (it == 2) begin y = 2000; mo = 2; d = 28; h = 23; m = 59; s = 59; end
      wr(0, 32'h3);
      wr(1, enc_time(h, m, s));
      wr(2, enc_cal(d, mo, y, wd));
      wr(0, 32'h0);
      wr(3, 32'h1F);
      minchg = 0; daychg = 0;
      k = 1 + int'($urandom_range(4));
      for (int j = 0; j < k; j++) begin tick(); advance(); end
      rd(1, v); check("R5 time rollover", v, enc_time(h, m, s));
      rd(2, v); check("R6 calendar rollover", v, enc_cal(d, mo, y, wd));
      check("R7 events", {sec_evt, min_evt, day_evt}, {1'b1, minchg, daychg});
    end

    // R2 calendar frozen while time runs into midnight: day carry dropped
    wr(0, 32'h3); wr(1, enc_time(23, 59, 59)); wr(2, enc_cal(5, 6, 2010, 3));
    wr(0, 32'h2); wr(3, 32'h1F);
    tick();
    rd(1, v); check("R2 time runs", v, 32'h0);
    rd(2, v); check("R2 cal held", v, enc_cal(5, 6, 2010, 3));
    check("R7 no day_evt when cal held", day_evt, 0);

    finish_run();
  end
endmodule